// File: doc/BRIEF.md
# LED Drive Enable Synchroniser with Total-Current Guard

This block gates three LED current channels (red, green, blue) for an image-sensor front end. Each channel has an asynchronous enable pin and a 3-bit current setting. A setting x asks for (x + 1) units of 8.4 mA, so one channel draws from 8.4 mA up to 67.2 mA in 12.5 % steps. The enable pins are brought into the system clock domain, and they act only when the sampling pulse has a falling edge. At that moment the block captures the enable pattern and the settings. It then drives the current code for each enabled channel.

A guard adds up the units asked for by the enabled channels. If the total exceeds a fixed budget of 12 units (100.8 mA, or 150 % of one channel at full scale), the guard switches every channel off. A channel enabled alone always fits within the budget. A power-down input turns all drive off at once.

The control is a four-state machine, and every state change except power-down happens on a detected falling edge of the sampling pulse:
- OFF: powered down, or just out of reset.
- IDLE: no channel captured as enabled.
- DRIVE: the captured channels are driven.
- BLOCKED: the captured load exceeds the budget.

From any state, power-down goes to OFF. From any state while powered, a falling edge goes to IDLE, DRIVE or BLOCKED according to the newly captured pattern. Without an event, the state holds, and that includes OFF after power returns.

Top module: `led_gate_top`

## Requirements
- R1: A falling edge of `samp_pulse_i` that is first sampled at clock edge k changes the outputs after clock edge k+SYNC_STAGES (edge k+2 by default), and not earlier.
- R2: A channel whose captured enable is 1 drives (`drive_en_o` bit = 1) when the captured load is within budget. A channel whose captured enable is 0 has `drive_en_o` = 0.
- R3: The code of channel i sits at `drive_code_o[3i+2:3i]` (bit 0 = red, 1 = green, 2 = blue in both `en_pin_i` and `drive_en_o`). It equals the setting captured at the last event while that channel drives, and 0 otherwise. Setting changes between events have no effect.
- R4: When the sum over the captured enabled channels of (setting + 1) is greater than 12, all `drive_en_o` bits and all codes are 0.
- R5: A load of exactly 12 units still drives. A single enabled channel drives at every setting, including 7.
- R6: When `pwr_on_i` is 0 at a clock edge, all outputs are 0 after that edge and the captured state is cleared. After power returns, the outputs stay 0 until the next falling-edge event.
- R7: Reset clears the captured enables and codes, and all outputs read 0.
- R8: Changes on `en_pin_i` while `samp_pulse_i` shows no falling edge leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_pulse_i | input | 1 | Sampling pulse, asynchronous; its falling edge is the capture event |
| en_pin_i | input | 3 | Per-channel enable pins, asynchronous |
| cur_code_i | input | 9 | Three 3-bit current settings, synchronous register values |
| pwr_on_i | input | 1 | 1 = normal operation, 0 = power-down |
| drive_en_o | output | 3 | Per-channel drive enable |
| drive_code_o | output | 9 | Per-channel current code, zero when not driving |

## Verification
The assertions assume the following about the inputs:
- `cur_code_i` and `pwr_on_i` are synchronous to `clk`.
- `en_pin_i` is steady across each falling edge of `samp_pulse_i`, so the enable pattern and the pulse pass through the same synchroniser depth.
- The pulse stays high and low for several clocks.

The stimulus meets these conditions. It changes enables and settings only on the falling clock edge and only while the pulse is high or long settled. It holds every pulse phase for at least three clocks, which allows the output-stability property to use a quiet window measured in clocks since the pulse last changed.

// File: rtl/led_gate_pkg.sv
package led_gate_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_IDLE    = 2'd1,
        ST_DRIVE   = 2'd2,
        ST_BLOCKED = 2'd3
    } drv_state_e;

endpackage

// File: rtl/led_pulse_sync.sv
module led_pulse_sync #(
    parameter int STAGES = 2,
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_i,
    input  logic [NUM_CH-1:0] en_i,
    output logic              fall_o,
    output logic [NUM_CH-1:0] en_sync_o
);

    localparam int DW = NUM_CH + 1;

    logic [DW-1:0] pipe_q [STAGES];
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q[0] <= '0;
        end else begin
            pipe_q[0] <= {en_i, samp_i};
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q[g] <= '0;
                end else begin
                    pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pipe_q[STAGES-1][0];
        end
    end

    assign fall_o    = prev_q & ~pipe_q[STAGES-1][0];
    assign en_sync_o = pipe_q[STAGES-1][DW-1:1];

endmodule

// File: rtl/led_budget.sv
module led_budget #(
    parameter int NUM_CH = 3,
    parameter int CODE_W = 3,
    parameter int BUDGET = 12
) (
    input  logic [NUM_CH-1:0]        en_i,
    input  logic [NUM_CH*CODE_W-1:0] code_i,
    output logic                     any_o,
    output logic                     over_o
);

    localparam int SUM_W = $clog2(NUM_CH * (1 << CODE_W) + 1) + 1;

    logic [SUM_W-1:0] load;

    always_comb begin
        load = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (en_i[c]) begin
                load = load + SUM_W'(code_i[c*CODE_W +: CODE_W]) + SUM_W'(1);
            end
        end
    end

    assign any_o  = |en_i;
    assign over_o = (load > SUM_W'(BUDGET));

endmodule

// File: rtl/led_gate_fsm.sv
module led_gate_fsm
    import led_gate_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CODE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_on_i,
    input  logic                     fall_i,
    input  logic [NUM_CH-1:0]        en_sync_i,
    input  logic [NUM_CH*CODE_W-1:0] code_i,
    input  logic                     any_i,
    input  logic                     over_i,
    output logic [NUM_CH-1:0]        drive_en_o,
    output logic [NUM_CH*CODE_W-1:0] drive_code_o
);

    drv_state_e                state_q, state_nxt;
    logic [NUM_CH-1:0]         cap_en_q;
    logic [NUM_CH*CODE_W-1:0]  cap_code_q;

    // Outcome of a capture event
    drv_state_e event_state;
    always_comb begin
        if (!any_i) begin
            event_state = ST_IDLE;
        end else if (over_i) begin
            event_state = ST_BLOCKED;
        end else begin
            event_state = ST_DRIVE;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (pwr_on_i && fall_i) state_nxt = event_state;
            end
            ST_IDLE: begin
                if (!pwr_on_i)   state_nxt = ST_OFF;
                else if (fall_i) state_nxt = event_state;
            end
            ST_DRIVE: begin
                if (!pwr_on_i)   state_nxt = ST_OFF;
                else if (fall_i) state_nxt = event_state;
            end
            ST_BLOCKED: begin
                if (!pwr_on_i)   state_nxt = ST_OFF;
                else if (fall_i) state_nxt = event_state;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_en_q   <= '0;
            cap_code_q <= '0;
        end else if (!pwr_on_i) begin
            cap_en_q   <= '0;
            cap_code_q <= '0;
        end else if (fall_i) begin
            cap_en_q   <= en_sync_i;
            cap_code_q <= code_i;
        end
    end

    always_comb begin
        drive_en_o   = '0;
        drive_code_o = '0;
        unique case (state_q)
            ST_DRIVE: begin
                drive_en_o = cap_en_q;
                for (int c = 0; c < NUM_CH; c++) begin
                    if (cap_en_q[c]) begin
                        drive_code_o[c*CODE_W +: CODE_W] = cap_code_q[c*CODE_W +: CODE_W];
                    end
                end
            end
            ST_OFF, ST_IDLE, ST_BLOCKED: begin
                drive_en_o   = '0;
                drive_code_o = '0;
            end
            default: begin
                drive_en_o   = '0;
                drive_code_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/led_gate_top.sv
module led_gate_top #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CH      = 3,
    parameter int CODE_W      = 3,
    parameter int BUDGET      = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_pulse_i,
    input  logic [NUM_CH-1:0]        en_pin_i,
    input  logic [NUM_CH*CODE_W-1:0] cur_code_i,
    input  logic                     pwr_on_i,
    output logic [NUM_CH-1:0]        drive_en_o,
    output logic [NUM_CH*CODE_W-1:0] drive_code_o
);

    logic              fall;
    logic [NUM_CH-1:0] en_sync;
    logic              any_en;
    logic              over_budget;

    led_pulse_sync #(
        .STAGES (SYNC_STAGES),
        .NUM_CH (NUM_CH)
    ) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_i    (samp_pulse_i),
        .en_i      (en_pin_i),
        .fall_o    (fall),
        .en_sync_o (en_sync)
    );

    led_budget #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .BUDGET (BUDGET)
    ) budget_i (
        .en_i   (en_sync),
        .code_i (cur_code_i),
        .any_o  (any_en),
        .over_o (over_budget)
    );

    led_gate_fsm #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_on_i     (pwr_on_i),
        .fall_i       (fall),
        .en_sync_i    (en_sync),
        .code_i       (cur_code_i),
        .any_i        (any_en),
        .over_i       (over_budget),
        .drive_en_o   (drive_en_o),
        .drive_code_o (drive_code_o)
    );

endmodule

// File: rtl/led_gate_chk.sv
module led_gate_chk #(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CH      = 3,
    parameter int CODE_W      = 3,
    parameter int BUDGET      = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     samp_pulse_i,
    input logic                     pwr_on_i,
    input logic [NUM_CH-1:0]        drive_en_o,
    input logic [NUM_CH*CODE_W-1:0] drive_code_o
);

    localparam int LOAD_W  = 16;
    localparam int QUIET_N = SYNC_STAGES + 3;

    logic [LOAD_W-1:0] load;
    logic              idle_code_bad;
    logic              samp_q;
    logic              pwr_q;
    logic [7:0]        quiet_cnt;

    always_comb begin
        load          = '0;
        idle_code_bad = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (drive_en_o[c]) begin
                load = load + LOAD_W'(drive_code_o[c*CODE_W +: CODE_W]) + LOAD_W'(1);
            end else if (drive_code_o[c*CODE_W +: CODE_W] != '0) begin
                idle_code_bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q    <= 1'b0;
            pwr_q     <= 1'b0;
            quiet_cnt <= '0;
        end else begin
            samp_q <= samp_pulse_i;
            pwr_q  <= pwr_on_i;
            if (samp_pulse_i != samp_q) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt != 8'hFF) begin
                quiet_cnt <= quiet_cnt + 8'd1;
            end
        end
    end

    // R4: driven load never exceeds the budget
    a_r4_load_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
        load <= LOAD_W'(BUDGET));

    // R6: power-down turns every channel off on the next cycle
    a_r6_pwr_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on_i |=> (drive_en_o == '0));

    // R3: a channel that is not driving reports code 0
    a_r3_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_code_bad);

    // R8: with no recent pulse activity and steady power, outputs hold
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt >= 8'(QUIET_N) && pwr_on_i && pwr_q) |=>
            ($stable(drive_en_o) && $stable(drive_code_o)));

endmodule

bind led_gate_top led_gate_chk #(
    .SYNC_STAGES (SYNC_STAGES),
    .NUM_CH      (NUM_CH),
    .CODE_W      (CODE_W),
    .BUDGET      (BUDGET)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_pulse_i (samp_pulse_i),
    .pwr_on_i     (pwr_on_i),
    .drive_en_o   (drive_en_o),
    .drive_code_o (drive_code_o)
);

// File: tb/led_gate_top_tb_top.sv
module led_gate_top_tb_top;

    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp = 1'b0;
    logic [2:0] en = 3'b000;
    logic [8:0] codes = 9'd0;
    logic       pwr = 1'b0;
    logic [2:0] drive_en;
    logic [8:0] drive_code;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    led_gate_top #(.SYNC_STAGES(S)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_pulse_i (samp),
        .en_pin_i     (en),
        .cur_code_i   (codes),
        .pwr_on_i     (pwr),
        .drive_en_o   (drive_en),
        .drive_code_o (drive_code)
    );

    // Behavioural reference model
    logic [3:0] hist[$];
    logic [2:0] m_cap_en;
    logic [8:0] m_cap_code;
    int         m_state;      // 0 off, 1 idle, 2 drive, 3 blocked
    logic [2:0] exp_en;
    logic [8:0] exp_code;

    initial begin
        for (int i = 0; i < S + 2; i++) hist.push_back(4'd0);
        m_cap_en = 0; m_cap_code = 0; m_state = 0; exp_en = 0; exp_code = 0;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.push_back(4'd0);
            m_state = 0; m_cap_en = 0; m_cap_code = 0;
        end else begin
            logic [3:0] last, prev;
            hist.push_back({en, samp});
            last = hist[hist.size() - 1 - S];
            prev = hist[hist.size() - 2 - S];
            if (!pwr) begin
                m_state = 0; m_cap_en = 0; m_cap_code = 0;
            end else if (prev[0] && !last[0]) begin
                int units;
                m_cap_en   = last[3:1];
                m_cap_code = codes;
                units = 0;
                for (int c = 0; c < 3; c++)
                    if (m_cap_en[c]) units += int'(codes[c*3 +: 3]) + 1;
                if (m_cap_en == 0)  m_state = 1;
                else if (units > 12) m_state = 3;
                else                 m_state = 2;
            end
        end
        while (hist.size() > 8) void'(hist.pop_front());
        exp_en = 0; exp_code = 0;
        if (m_state == 2) begin
            exp_en = m_cap_en;
            for (int c = 0; c < 3; c++)
                if (m_cap_en[c]) exp_code[c*3 +: 3] = m_cap_code[c*3 +: 3];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(drive_en == exp_en, "R2/R4 model drive_en", 32'(drive_en), 32'(exp_en));
            chk(drive_code == exp_code, "R3/R4 model drive_code", 32'(drive_code), 32'(exp_code));
        end
    end

    task automatic expect_out(input string req, input logic [2:0] e_en, input logic [8:0] e_code);
        chk(drive_en == e_en, req, 32'(drive_en), 32'(e_en));
        chk(drive_code == e_code, req, 32'(drive_code), 32'(e_code));
    endtask

    task automatic pulse();
        @(negedge clk) samp = 1'b1;
        repeat (3) @(negedge clk);
        samp = 1'b0;
        repeat (S + 4) @(negedge clk);
    endtask

    task automatic setup(input logic [2:0] e, input logic [2:0] r, input logic [2:0] g, input logic [2:0] b);
        @(negedge clk);
        en = e;
        codes = {b, g, r};
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R7 reset state", 3'b000, 9'd0);
        pwr = 1'b1;

        setup(3'b001, 3'd7, 3'd0, 3'd0);
        pulse();
        expect_out("R2 red on, R5 single at 7", 3'b001, 9'h007);

        @(negedge clk) en = 3'b010;
        repeat (20) @(negedge clk);
        expect_out("R8 enable change without pulse", 3'b001, 9'h007);

        @(negedge clk) codes = 9'h003;
        repeat (10) @(negedge clk);
        expect_out("R3 setting change without pulse", 3'b001, 9'h007);

        setup(3'b111, 3'd3, 3'd3, 3'd3);
        pulse();
        expect_out("R5 load exactly 12 drives", 3'b111, 9'o333);

        setup(3'b111, 3'd3, 3'd3, 3'd4);
        pulse();
        expect_out("R4 load 13 blocked", 3'b000, 9'd0);

        setup(3'b001, 3'd7, 3'd3, 3'd4);
        pulse();
        expect_out("R5 single channel drives", 3'b001, 9'h007);

        setup(3'b011, 3'd7, 3'd3, 3'd4);
        pulse();
        expect_out("R3 pair at 12 drives, blue code 0", 3'b011, 9'o037);

        setup(3'b011, 3'd7, 3'd4, 3'd0);
        pulse();
        expect_out("R4 pair at 13 blocked", 3'b000, 9'd0);

        setup(3'b011, 3'd7, 3'd3, 3'd0);
        pulse();
        expect_out("R2 pair drives", 3'b011, 9'o037);
        @(negedge clk) pwr = 1'b0;
        @(negedge clk);
        expect_out("R6 power-down off", 3'b000, 9'd0);
        @(negedge clk) pwr = 1'b1;
        repeat (10) @(negedge clk);
        expect_out("R6 stays off until event", 3'b000, 9'd0);
        pulse();
        expect_out("R6 event after power return", 3'b011, 9'o037);

        setup(3'b000, 3'd7, 3'd3, 3'd0);
        pulse();
        expect_out("R2 all captured low", 3'b000, 9'd0);

        // R1 latency from pulse fall
        setup(3'b100, 3'd0, 3'd0, 3'd5);
        @(negedge clk) samp = 1'b1;
        repeat (3) @(negedge clk);
        samp = 1'b0;
        repeat (S) begin
            @(negedge clk);
            expect_out("R1 not before latency", 3'b000, 9'd0);
        end
        @(negedge clk);
        expect_out("R1 change at latency", 3'b100, 9'o500);

        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        expect_out("R7 reset clears drive", 3'b000, 9'd0);
        en = 3'b000;
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);
        expect_out("R7 after reset release", 3'b000, 9'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule